// File: doc/BRIEF.md
# Load Miss Scoreboard

This block keeps track of loads that missed in a primary data cache whose lookup takes two cycles. After a miss the instruction stream keeps issuing. The block records which register each outstanding miss will write. An instruction is held back only when it reads a register that is still waiting for a fill, when it would overwrite such a register, or when it is a load and every tracking entry is already in use.

Refill data can come from the second-level cache after about 15 cycles or from main memory after more than 60 cycles. Fills can therefore return in any order. Each fill carries the tag that the block gave out when the miss was allocated. That tag selects the recorded destination register, which is written back on the next cycle.

Each tracking entry is a two-state machine. The states are `ENT_IDLE` (free) and `ENT_WAIT` (holding a destination register). The transition *allocate* moves an entry from `ENT_IDLE` to `ENT_WAIT` when a miss is accepted and the entry is the lowest free one. The transition *fill* moves it from `ENT_WAIT` back to `ENT_IDLE` when a fill arrives with that entry's tag. A separate per-register pending vector feeds the issue stall check.

Top module: `ld_miss_scoreboard`

## Requirements
- R1: After reset no register is pending, `full` is 0, `wb_valid` is 0 and `miss_tag` is 0.
- R2: The lowest-numbered free entry is offered on `miss_tag`, and is 0 when all entries are busy. A `miss_valid` while not full takes that entry and records `miss_dst`. The register reads as pending from the next cycle.
- R3: `stall` is 1 when `iss_valid` is 1 and an enabled source specifier names a pending register.
- R4: An issuing instruction whose enabled specifiers name no pending register does not stall, even while misses are outstanding, unless R5 or R6 applies.
- R5: `stall` is 1 when `iss_valid` and `iss_dst_en` are 1 and `iss_dst` is pending.
- R6: `full` is 1 exactly when all `NUM_TAGS` entries are busy. While full, an issuing load (`iss_is_load`=1) stalls, and a `miss_valid` is ignored: no entry is taken and no register becomes pending.
- R7: A `fill_valid` whose `fill_tag` names a busy entry produces `wb_valid`=1 on the next cycle. `wb_reg` then equals that entry's recorded register and `wb_data` equals `fill_data`. On the same edge the entry is freed and the register's pending bit is cleared, so a consumer waiting on it issues without stall in that next cycle.
- R8: Fills may return in any tag order, and each one writes back the register recorded for its own tag.
- R9: A fill whose tag names a free entry is ignored: there is no writeback, and the pending state does not change.
- R10: Source or destination specifiers whose enable is 0 never cause a stall, and `stall` is 0 whenever `iss_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_src_a | input | REG_W | First source register |
| iss_src_a_en | input | 1 | First source is used |
| iss_src_b | input | REG_W | Second source register |
| iss_src_b_en | input | 1 | Second source is used |
| iss_dst | input | REG_W | Destination register |
| iss_dst_en | input | 1 | Destination is written |
| iss_is_load | input | 1 | The issuing instruction is a load |
| miss_valid | input | 1 | A load missed in the primary cache |
| miss_dst | input | REG_W | Destination register of the missing load |
| miss_tag | output | TAG_W | Tag given to a miss allocated this cycle |
| fill_valid | input | 1 | Refill response present |
| fill_tag | input | TAG_W | Tag of the refill response |
| fill_data | input | DATA_W | Refill data |
| stall | output | 1 | Hold the presented instruction |
| wb_valid | output | 1 | Register writeback valid |
| wb_reg | output | REG_W | Register being written back |
| wb_data | output | DATA_W | Writeback data |
| full | output | 1 | All tracking entries busy |

## Verification
The bench fills every entry and then sends a further miss to a new register. A design that accepted this miss would stall a later reader of that register, or would hand out an entry twice. Fills are returned in reverse and scrambled tag order. A design that wrote back in allocation order would show the wrong register on `wb_reg`. A consumer issued in the cycle right after its fill catches a pending bit that clears one cycle late. A fill to a free tag catches a block that writes back stale registers. Disabled specifiers that name pending registers catch a stall that ignores the enables.

// File: rtl/lms_pkg.sv
package lms_pkg;
    typedef enum logic {
        ENT_IDLE = 1'b0,
        ENT_WAIT = 1'b1
    } ent_state_t;
endpackage

// File: rtl/lms_entry.sv
module lms_entry
    import lms_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [REG_W-1:0] alloc_reg,
    input  logic             fill_hit,
    output logic             busy,
    output logic [REG_W-1:0] dst_reg
);
    ent_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_IDLE;
            dst_reg <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ENT_IDLE && alloc) dst_reg <= alloc_reg;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_IDLE: if (alloc)    state_d = ENT_WAIT;
            ENT_WAIT: if (fill_hit) state_d = ENT_IDLE;
            default:                state_d = ENT_IDLE;
        endcase
    end

    assign busy = (state_q == ENT_WAIT);
endmodule

// File: rtl/lms_pend_vec.sv
module lms_pend_vec #(
    parameter int NUM_REGS = 32,
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [REG_W-1:0]    set_idx,
    input  logic                clr_en,
    input  logic [REG_W-1:0]    clr_idx,
    output logic [NUM_REGS-1:0] pend
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            if (clr_en) pend[clr_idx] <= 1'b0;
            if (set_en) pend[set_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/ld_miss_scoreboard.sv
module ld_miss_scoreboard #(
    parameter int NUM_REGS = 32,
    parameter int NUM_TAGS = 4,
    parameter int DATA_W   = 64,
    localparam int REG_W = $clog2(NUM_REGS),
    localparam int TAG_W = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [REG_W-1:0]  iss_src_a,
    input  logic              iss_src_a_en,
    input  logic [REG_W-1:0]  iss_src_b,
    input  logic              iss_src_b_en,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic              iss_dst_en,
    input  logic              iss_is_load,
    input  logic              miss_valid,
    input  logic [REG_W-1:0]  miss_dst,
    output logic [TAG_W-1:0]  miss_tag,
    input  logic              fill_valid,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    output logic              stall,
    output logic              wb_valid,
    output logic [REG_W-1:0]  wb_reg,
    output logic [DATA_W-1:0] wb_data,
    output logic              full
);
    logic [NUM_TAGS-1:0] ent_busy;
    logic [REG_W-1:0]    ent_reg [NUM_TAGS];
    logic [NUM_REGS-1:0] pend;
    logic [TAG_W-1:0]    free_idx;
    logic                alloc_ok;
    logic                fill_ok;
    logic [REG_W-1:0]    fill_reg;

    // lowest free entry
    always_comb begin
        free_idx = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (!ent_busy[i]) free_idx = TAG_W'(i);
        end
    end

    assign full     = &ent_busy;
    assign alloc_ok = miss_valid && !full;
    assign miss_tag = full ? '0 : free_idx;
    assign fill_ok  = fill_valid && ent_busy[fill_tag];
    assign fill_reg = ent_reg[fill_tag];

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_ent
        lms_entry #(.REG_W(REG_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc_ok && (free_idx == TAG_W'(g))),
            .alloc_reg(miss_dst),
            .fill_hit (fill_valid && (fill_tag == TAG_W'(g))),
            .busy     (ent_busy[g]),
            .dst_reg  (ent_reg[g])
        );
    end

    lms_pend_vec #(.NUM_REGS(NUM_REGS)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (alloc_ok),
        .set_idx(miss_dst),
        .clr_en (fill_ok),
        .clr_idx(fill_reg),
        .pend   (pend)
    );

    always_comb begin
        stall = 1'b0;
        if (iss_valid) begin
            stall = (iss_src_a_en && pend[iss_src_a])
                 || (iss_src_b_en && pend[iss_src_b])
                 || (iss_dst_en   && pend[iss_dst])
                 || (iss_is_load  && full);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_reg   <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= fill_ok;
            if (fill_ok) begin
                wb_reg  <= fill_reg;
                wb_data <= fill_data;
            end
        end
    end
endmodule

// File: rtl/ld_miss_scoreboard_chk.sv
module ld_miss_scoreboard_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic              stall,
    input logic              full,
    input logic              miss_valid,
    input logic              fill_valid,
    input logic [DATA_W-1:0] fill_data,
    input logic              wb_valid,
    input logic [DATA_W-1:0] wb_data
);
    a_r7_wb_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(fill_valid));

    a_r7_wb_data: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_data == $past(fill_data));

    a_r10_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> !stall);

    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !fill_valid) |=> full);

    a_r6_miss_ignored_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && miss_valid && !fill_valid) |=> full);
endmodule

bind ld_miss_scoreboard ld_miss_scoreboard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .stall     (stall),
    .full      (full),
    .miss_valid(miss_valid),
    .fill_valid(fill_valid),
    .fill_data (fill_data),
    .wb_valid  (wb_valid),
    .wb_data   (wb_data)
);

// File: tb/test_ld_miss_scoreboard.sv
`timescale 1ns/1ps
module test_ld_miss_scoreboard;
    localparam int NR = 32;
    localparam int NT = 4;
    localparam int DW = 64;

    logic clk = 0;
    logic rst_n = 0;
    logic iss_valid = 0, iss_src_a_en = 0, iss_src_b_en = 0, iss_dst_en = 0, iss_is_load = 0;
    logic [4:0] iss_src_a = 0, iss_src_b = 0, iss_dst = 0, miss_dst = 0;
    logic miss_valid = 0, fill_valid = 0;
    logic [1:0] fill_tag = 0;
    logic [DW-1:0] fill_data = 0;
    logic [1:0] miss_tag;
    logic stall, wb_valid, full;
    logic [4:0] wb_reg;
    logic [DW-1:0] wb_data;

    always #2 clk = ~clk;

    ld_miss_scoreboard #(.NUM_REGS(NR), .NUM_TAGS(NT), .DATA_W(DW)) i_ld_miss_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_a_en(iss_src_a_en),
        .iss_src_b(iss_src_b), .iss_src_b_en(iss_src_b_en),
        .iss_dst(iss_dst), .iss_dst_en(iss_dst_en), .iss_is_load(iss_is_load),
        .miss_valid(miss_valid), .miss_dst(miss_dst), .miss_tag(miss_tag),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
        .stall(stall), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data), .full(full)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    bit pend_m [NR];
    bit busy_m [NT];
    int reg_m  [NT];
    bit exp_wb_v = 0;
    int exp_wb_r = 0;
    logic [DW-1:0] exp_wb_d = 0;

    function automatic bit m_full();
        for (int i = 0; i < NT; i++) if (!busy_m[i]) return 0;
        return 1;
    endfunction

    function automatic int m_free();
        for (int i = 0; i < NT; i++) if (!busy_m[i]) return i;
        return 0;
    endfunction

    function automatic bit m_stall();
        if (!iss_valid) return 0;
        return (iss_src_a_en && pend_m[iss_src_a]) || (iss_src_b_en && pend_m[iss_src_b])
            || (iss_dst_en && pend_m[iss_dst]) || (iss_is_load && m_full());
    endfunction

    task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit f = m_full();
        int t = m_free();
        exp_wb_v = fill_valid && busy_m[fill_tag];
        if (exp_wb_v) begin
            exp_wb_r = reg_m[fill_tag];
            exp_wb_d = fill_data;
            busy_m[fill_tag] = 0;
            pend_m[exp_wb_r] = 0;
        end
        if (miss_valid && !f) begin
            busy_m[t] = 1;
            reg_m[t] = miss_dst;
            pend_m[miss_dst] = 1;
        end
    endtask

    // called at a negedge with inputs set
    task automatic step(string req);
        #1;
        check(req, "stall", DW'(stall), DW'(m_stall()));
        check("R6", "full", DW'(full), DW'(m_full()));
        check("R2", "miss_tag", DW'(miss_tag), DW'(m_full() ? 0 : m_free()));
        check("R7", "wb_valid", DW'(wb_valid), DW'(exp_wb_v));
        if (exp_wb_v) begin
            check("R8", "wb_reg", DW'(wb_reg), DW'(exp_wb_r));
            check("R7", "wb_data", wb_data, exp_wb_d);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle_in();
        iss_valid = 0; iss_src_a_en = 0; iss_src_b_en = 0; iss_dst_en = 0; iss_is_load = 0;
        miss_valid = 0; fill_valid = 0;
    endtask

    task automatic issue(int a, bit ae, int b, bit be, int d, bit de, bit ld);
        iss_valid = 1;
        iss_src_a = 5'(a); iss_src_a_en = ae;
        iss_src_b = 5'(b); iss_src_b_en = be;
        iss_dst = 5'(d); iss_dst_en = de; iss_is_load = ld;
    endtask

    task automatic miss(int d);
        miss_valid = 1; miss_dst = 5'(d);
    endtask

    task automatic fill(int t, logic [DW-1:0] d);
        fill_valid = 1; fill_tag = 2'(t); fill_data = d;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) pend_m[i] = 0;
        for (int i = 0; i < NT; i++) begin busy_m[i] = 0; reg_m[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        #1;
        check("R1", "full", DW'(full), 0);
        check("R1", "wb_valid", DW'(wb_valid), 0);
        check("R1", "miss_tag", DW'(miss_tag), 0);
        @(negedge clk);
        issue(1, 1, 2, 1, 3, 1, 1);
        step("R1");

        // R2 allocate r5 on tag 0
        idle_in(); miss(5);
        step("R2");
        // R3 reader of r5 stalls; R4 unrelated reader does not
        idle_in(); issue(5, 1, 0, 0, 9, 1, 0);
        step("R3");
        idle_in(); issue(7, 1, 8, 1, 9, 1, 1);
        step("R4");
        idle_in(); issue(1, 1, 5, 1, 9, 1, 0);
        step("R3");

        // R6 fill all entries
        idle_in(); miss(6); step("R2");
        idle_in(); miss(7); step("R2");
        idle_in(); miss(8); issue(10, 1, 11, 1, 12, 1, 0); step("R4");
        idle_in(); issue(10, 1, 11, 1, 12, 1, 1); step("R6");
        idle_in(); miss(9); step("R6");
        idle_in(); issue(9, 1, 0, 0, 0, 0, 0); step("R6");

        // R5 write-after-pending
        idle_in(); issue(1, 1, 2, 1, 6, 1, 0); step("R5");
        // R10 disabled specifiers
        idle_in(); issue(6, 0, 7, 0, 8, 0, 0); step("R10");
        idle_in(); iss_src_a = 5; iss_src_a_en = 1; step("R10");

        // R8 out-of-order fills: tag2 (r7) then tag0 (r5)
        idle_in(); fill(2, 64'hA5A5_0000_1111_2222); step("R8");
        idle_in(); fill(0, 64'h0123_4567_89AB_CDEF); issue(7, 1, 0, 0, 0, 0, 0); step("R7");
        idle_in(); issue(5, 1, 7, 1, 0, 0, 0); step("R7");
        // R9 fill to free tag 2
        idle_in(); fill(2, 64'hDEAD_BEEF_0000_0001); step("R9");
        idle_in(); issue(6, 1, 8, 1, 0, 0, 0); step("R9");
        // fill and allocate in same cycle
        idle_in(); fill(3, 64'h55); miss(20); step("R8");
        idle_in(); fill(1, 64'h66); issue(20, 1, 0, 0, 0, 0, 1); step("R3");
        idle_in(); fill(0, 64'h77); step("R8");

        // random traffic
        for (int n = 0; n < 2000; n++) begin
            idle_in();
            if ($urandom_range(0, 1) == 1)
                issue($urandom_range(0, 7), $urandom_range(0, 1) == 1, $urandom_range(0, 7),
                      $urandom_range(0, 1) == 1, $urandom_range(0, 7),
                      $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
            if ($urandom_range(0, 2) == 0) miss($urandom_range(0, 7));
            if ($urandom_range(0, 2) == 0) fill($urandom_range(0, 3), {$urandom, $urandom});
            step("R4");
        end
        idle_in();
        step("R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule